// File: doc/BRIEF.md
# Multiplexed Four-Digit Decimal Display Driver

This block shows an unsigned binary value as decimal digits on four time-shared 7-segment positions. A holding register takes the value from the processor's data bus on any main-clock edge where the load strobe is high. A small scan state machine steps through the four positions, one step for each cycle where the scan enable is high. The scan enable is separate from the processor's run and halt logic, so the display keeps refreshing after the processor stops.

For the active position the driver raises exactly one position enable. It also drives the segment pattern of the decimal digit that belongs to that position. One lookup takes both the stored value and the scan position. It does the binary-to-decimal digit extraction and the segment encoding in one step. Position 0 shows the units digit, position 1 the tens and position 2 the hundreds. Position 3 is always dark, because an 8-bit value never goes past 255.

The scan machine has four named states: SCAN_UNITS, SCAN_TENS, SCAN_HUNDREDS and SCAN_TOP. Its transitions are UNITS→TENS, TENS→HUNDREDS, HUNDREDS→TOP and TOP→UNITS. Each transition is taken on a cycle where `scan_en` is high. When `scan_en` is low, every state stays where it is.

Top module: `seg_scan_display`

## Requirements
- R1: While `rst` is high at a clock edge, the held value is cleared to 0 and the scan state returns to SCAN_UNITS. After reset the outputs are `dig_en_o` = 4'b0001 and `seg_o` = 7'h3F.
- R2: On a rising edge with `load_en` high, the held value takes `bus_in`. The new value shows on `seg_o` right after that edge.
- R3: On a rising edge with `load_en` low, the held value does not change, whatever `bus_in` carries.
- R4: On each rising edge with `scan_en` high, the scan position advances by one: UNITS→TENS→HUNDREDS→TOP→UNITS. Position 3 wraps to 0.
- R5: On a rising edge with `scan_en` low, the scan position stays the same.
- R6: `dig_en_o` is one-hot at all times after reset. Bit k is high exactly when the scan position is k.
- R7: Position 0 shows value mod 10, position 1 shows (value/10) mod 10, and position 2 shows (value/100) mod 10.
- R8: Position 3 (`dig_en_o[3]` high) always drives `seg_o` = 7'h00.
- R9: `seg_o` is active-high with bit 0 = segment a through bit 6 = segment g. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R10: Loading and scanning do not affect each other. A load leaves the scan position unchanged, and scanning leaves the held value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Capture strobe for the held value |
| bus_in | input | DATA_W (8) | Processor data bus |
| scan_en | input | 1 | Advance pulse for the scan position, not gated by halt |
| seg_o | output | 7 | Segment pattern, active high, bit 0 = a … bit 6 = g |
| dig_en_o | output | 4 | One-hot position enable, active high |

## Verification
The bench builds the driver with its default DATA_W of 8. At that width every storable value can be covered. Each of the 256 values is loaded and then scanned through all four positions, so the whole decimal lookup is checked, including the carry points at 9/10, 99/100 and 255. A seeded random phase then mixes load and scan strobes, which reaches the combinations of simultaneous load, scan, hold and wrap.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int NUM_POS = 4;
    localparam int SEG_W   = 7;

    typedef enum logic [1:0] {
        SCAN_UNITS    = 2'd0,
        SCAN_TENS     = 2'd1,
        SCAN_HUNDREDS = 2'd2,
        SCAN_TOP      = 2'd3
    } scan_pos_e;

    // Active-high segment code, bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] seg_of_digit(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        unique case (d)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp_value_reg.sv
module disp_value_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] value_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (load_en) begin
            value_q <= bus_in;
        end
    end

    // R2: a strobed load shows the bus value one edge later
    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (value_q == $past(bus_in)));

    // R3: without the strobe the value is held
    a_r3_hold_value: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(value_q));

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import seg_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_en,
    output scan_pos_e          pos_o,
    output logic [NUM_POS-1:0] dig_en_o
);

    scan_pos_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_UNITS;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (scan_en) begin
            unique case (state_q)
                SCAN_UNITS:    state_d = SCAN_TENS;
                SCAN_TENS:     state_d = SCAN_HUNDREDS;
                SCAN_HUNDREDS: state_d = SCAN_TOP;
                SCAN_TOP:      state_d = SCAN_UNITS;
                default:       state_d = SCAN_UNITS;
            endcase
        end
    end

    assign pos_o = state_q;

    // Outputs: one-hot position decoder
    generate
        for (genvar g = 0; g < NUM_POS; g++) begin : g_dec
            assign dig_en_o[g] = (state_q == scan_pos_e'(g));
        end
    endgenerate

    // R4: one step per enabled edge, wrapping after position 3
    a_r4_advance: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (2'(state_q) == 2'($past(state_q) + 2'd1)));

    // R5: no step without enable
    a_r5_hold_pos: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(state_q));

endmodule

// File: rtl/digit_lut.sv
module digit_lut
    import seg_scan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value_i,
    input  scan_pos_e         pos_i,
    output logic [SEG_W-1:0]  seg_o
);

    localparam int VAL_MAX = (1 << DATA_W) - 1;

    function automatic logic [3:0] pick_digit(input int v, input scan_pos_e p);
        logic [3:0] d;
        unique case (p)
            SCAN_UNITS:    d = 4'(v % 10);
            SCAN_TENS:     d = 4'((v / 10) % 10);
            SCAN_HUNDREDS: d = 4'((v / 100) % 10);
            default:       d = 4'hF;
        endcase
        return d;
    endfunction

    int val_int;
    always_comb begin
        val_int = int'(value_i);
        if (val_int > VAL_MAX) val_int = VAL_MAX;
        seg_o = seg_of_digit(pick_digit(val_int, pos_i));
    end

endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display
    import seg_scan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              scan_en,
    output logic [6:0]        seg_o,
    output logic [3:0]        dig_en_o
);

    logic [DATA_W-1:0] value_q;
    scan_pos_e         pos;

    disp_value_reg #(.DATA_W(DATA_W)) u_value (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .bus_in  (bus_in),
        .value_q (value_q)
    );

    scan_fsm u_scan (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .pos_o    (pos),
        .dig_en_o (dig_en_o)
    );

    digit_lut #(.DATA_W(DATA_W)) u_lut (
        .value_i (value_q),
        .pos_i   (pos),
        .seg_o   (seg_o)
    );

    // R6: exactly one position lit
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_en_o) == 1);

    // R8: the top position stays dark
    a_r8_top_dark: assert property (@(posedge clk) disable iff (rst)
        dig_en_o[3] |-> (seg_o == 7'h00));

endmodule

// File: tb/seg_scan_display_test.sv
`timescale 1ns/1ps
module seg_scan_display_test;

    logic       clk = 1'b0;
    logic       rst, load_en, scan_en;
    logic [7:0] bus_in;
    logic [6:0] seg_o;
    logic [3:0] dig_en_o;

    int checks = 0;
    int errors = 0;
    int m_val  = 0;
    int m_pos  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    seg_scan_display uut (
        .clk(clk), .rst(rst), .load_en(load_en), .bus_in(bus_in),
        .scan_en(scan_en), .seg_o(seg_o), .dig_en_o(dig_en_o)
    );

    function automatic logic [6:0] code_of(input int d);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return t[d];
    endfunction

    function automatic logic [6:0] exp_seg(input int v, input int p);
        if (p == 0) return code_of(v % 10);
        if (p == 1) return code_of((v / 10) % 10);
        if (p == 2) return code_of((v / 100) % 10);
        return 7'h00;
    endfunction

    task automatic check(input string req);
        logic [3:0] exp_en;
        logic [6:0] es;
        exp_en = 4'b0001 << m_pos;
        es = exp_seg(m_val, m_pos);
        checks++;
        if (dig_en_o !== exp_en || seg_o !== es) begin
            errors++;
            $display("FAIL %s: dig_en=%b seg=%h expected dig_en=%b seg=%h (val=%0d pos=%0d)",
                     req, dig_en_o, seg_o, exp_en, es, m_val, m_pos);
        end
    endtask

    // Drive at negedge, take the edge, update model, sample 1 ns later
    task automatic step(input bit le, input logic [7:0] d, input bit se);
        @(negedge clk);
        load_en = le; bus_in = d; scan_en = se;
        @(posedge clk);
        if (le) m_val = int'(d);
        if (se) m_pos = (m_pos + 1) % 4;
        #1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; load_en = 1'b0; scan_en = 1'b0; bus_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_in = 8'hA5; load_en = 1'b1; scan_en = 1'b1;
        @(posedge clk);
        #1;
        m_val = 0; m_pos = 0;
        check("R1 reset state");
        @(negedge clk);
        rst = 1'b0; load_en = 1'b0; scan_en = 1'b0;

        // R3: bus toggles without strobe, value unchanged
        step(0, 8'hFF, 0); check("R3 no load");
        step(0, 8'h77, 0); check("R3 no load, R5 no scan");

        // Exhaustive: every value, all four positions (R2 R7 R8 R9 R4)
        for (int v = 0; v < 256; v++) begin
            step(1, 8'(v), 0);
            check("R2 load");
            for (int p = 0; p < 4; p++) begin
                step(0, 8'(v ^ 8'h5A), 1);
                if (m_pos == 3) check("R8 top dark, R6 onehot");
                else if (m_pos == 0) check("R4 wrap, R7 units, R9 code");
                else check("R7 digit, R9 code, R4 advance");
            end
        end

        // R10: load and scan together, each independent
        step(1, 8'd199, 1); check("R10 load with scan");
        step(1, 8'd100, 0); check("R10 load keeps position");
        step(0, 8'd3,   1); check("R10 scan keeps value");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit le, se;
            le = ($urandom % 4) == 0;
            se = ($urandom % 2) == 0;
            step(le, 8'($urandom), se);
            check("R2 R3 R4 R5 R6 random");
        end

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; m_val = 0; m_pos = 0;
        check("R1 reset mid-run");
        @(negedge clk); rst = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule